// File: doc/BRIEF.md
# Tiling-Aware Buffer Copy Engine

This block moves a range of bytes from one place in a shared memory to another. A start command carries a source base, a destination base and a byte count. Before any data moves, the engine queries a kind-lookup port twice: first for the source base, then for the destination base. Each answer is an 8-bit memory kind code, and the engine classifies it as either pitch (linear) or tiled.

When exactly one side is tiled, the engine reorders the address bits of that side inside a 512-byte tile. It applies this to every transfer, at the running offset from the base. All other kind combinations give a straight linear copy. Data moves in 16-byte beats when the source, the destination and the size are all multiples of 16. Otherwise it moves one byte per transfer.

Each transfer is a read followed by a write on a single request/acknowledge memory port. When the last write is acknowledged, a one-cycle done pulse is raised.

Top module: `tile_copy_engine`

## Requirements
- R1: The kind codes 0x00 and 0xFD are pitch. Every other 8-bit code, including 0xFF, is tiled.
- R2: With a tiled source and a pitch destination, each read address is the permuted form of source base plus offset. Each write address is destination base plus offset.
- R3: With a pitch source and a tiled destination, each read address is source base plus offset. Each write address is the permuted form of destination base plus offset.
- R4: When both sides are pitch, or both are tiled, the copy is linear on both sides.
- R5: The permutation keeps bits 3:0 and every bit from 9 upward. The permuted bit 4 is the original bit 6, bit 5 is the original bit 4, bits 7:6 are the original bits 8:7, and bit 8 is the original bit 5.
- R6: If source, destination and size are all multiples of 16, every transfer is a 16-byte beat (mem_wide_o=1), with data byte i on bits 8i+7:8i. Otherwise every transfer is a single byte (mem_wide_o=0) on bits 7:0. A wide beat address always has bits 3:0 at zero.
- R7: The offset starts at zero and advances by 16 or 1 per transfer until it reaches the size.
- R8: A size-zero command raises done_o on the cycle after acceptance and makes no memory request.
- R9: Each read is acknowledged before its write is requested. The write data equals the read data. A pending request holds its address and direction until it is acknowledged.
- R10: cmd_ready_o is high only while idle. A command presented while busy is ignored.
- R11: On the first cycle after acceptance, kind_addr_o shows the source base. On the second cycle it shows the destination base. kind_req_o is high on both cycles.
- R12: done_o is high for exactly one cycle, on the cycle after the final write acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Engine idle, command accepted |
| cmd_src_i | input | AW | Source base address |
| cmd_dst_i | input | AW | Destination base address |
| cmd_size_i | input | AW | Byte count |
| kind_req_o | output | 1 | Kind lookup active |
| kind_addr_o | output | AW | Address being classified |
| kind_i | input | 8 | Kind code for kind_addr_o, same cycle |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_wide_o | output | 1 | 1 for a 16-byte beat, 0 for one byte |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | 128 | Write data |
| mem_rdata_i | input | 128 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Request completed this cycle |
| done_o | output | 1 | Command finished pulse |

## Verification
The two kind addresses are due on the first and second falling edges after the accepting clock edge, and the bench samples them exactly there. A size-zero done is due on the first falling edge after acceptance. For any other command, done is due one cycle after the final write acknowledge; the bench records the cycle of that acknowledge and compares it with the cycle in which done appears. The memory model acknowledges after a random delay of zero to two cycles. Memory contents and transfer counts are compared only after done, so the variable latency does not affect any check.

// File: rtl/tce_pkg.sv
package tce_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_KSRC, ST_KDST, ST_RD, ST_WR, ST_DONE} tce_state_e;
  typedef enum logic [1:0] {MODE_LIN, MODE_RD_SWZ, MODE_WR_SWZ} tce_mode_e;
  localparam logic [7:0] KIND_LINEAR    = 8'h00;
  localparam logic [7:0] KIND_LINEAR_NS = 8'hFD;
endpackage

// File: rtl/tce_kind_decode.sv
module tce_kind_decode import tce_pkg::*; #(
  parameter int KW = 8
) (
  input  logic [KW-1:0] kind_i,
  output logic          pitch_o
);
  assign pitch_o = (kind_i == KW'(KIND_LINEAR)) || (kind_i == KW'(KIND_LINEAR_NS));
endmodule

// File: rtl/tce_mode_sel.sv
module tce_mode_sel import tce_pkg::*; (
  input  logic      src_pitch_i,
  input  logic      dst_pitch_i,
  output tce_mode_e mode_o
);
  always_comb begin
    if (!src_pitch_i && dst_pitch_i)      mode_o = MODE_RD_SWZ;
    else if (src_pitch_i && !dst_pitch_i) mode_o = MODE_WR_SWZ;
    else                                  mode_o = MODE_LIN;
  end
endmodule

// File: rtl/tce_addr_swz.sv
module tce_addr_swz #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  always_comb begin
    addr_o      = addr_i;
    addr_o[4]   = addr_i[6];
    addr_o[5]   = addr_i[4];
    addr_o[7:6] = addr_i[8:7];
    addr_o[8]   = addr_i[5];
  end

  // R5
  always_comb begin
    perm_weight_chk: assert ($countones(addr_o) == $countones(addr_i));
  end
endmodule

// File: rtl/tce_xfer_ctr.sv
module tce_xfer_ctr #(
  parameter int AW         = 32,
  parameter int BEAT_BYTES = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  input  logic          wide_i,
  input  logic [AW-1:0] size_i,
  output logic [AW-1:0] off_o,
  output logic          last_o
);
  localparam logic [AW:0] BEAT_STEP = (AW+1)'(BEAT_BYTES);

  logic [AW-1:0] off_q;
  logic [AW:0]   nxt;

  assign nxt    = {1'b0, off_q} + (wide_i ? BEAT_STEP : (AW+1)'(1));
  assign last_o = nxt >= {1'b0, size_i};
  assign off_o  = off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     off_q <= '0;
    else if (clr_i)  off_q <= '0;
    else if (adv_i)  off_q <= nxt[AW-1:0];
  end

  // R7
  adv_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> (off_q < size_i));
endmodule

// File: rtl/tile_copy_engine.sv
module tile_copy_engine import tce_pkg::*; #(
  parameter int AW         = 32,
  parameter int BEAT_BYTES = 16,
  parameter int KW         = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  output logic                  cmd_ready_o,
  input  logic [AW-1:0]         cmd_src_i,
  input  logic [AW-1:0]         cmd_dst_i,
  input  logic [AW-1:0]         cmd_size_i,
  output logic                  kind_req_o,
  output logic [AW-1:0]         kind_addr_o,
  input  logic [KW-1:0]         kind_i,
  output logic                  mem_req_o,
  output logic                  mem_we_o,
  output logic                  mem_wide_o,
  output logic [AW-1:0]         mem_addr_o,
  output logic [BEAT_BYTES*8-1:0] mem_wdata_o,
  input  logic [BEAT_BYTES*8-1:0] mem_rdata_i,
  input  logic                  mem_ack_i,
  output logic                  done_o
);
  localparam int DW = BEAT_BYTES * 8;
  localparam int BW = $clog2(BEAT_BYTES);
  localparam logic [AW-1:0] ALIGN_MASK = AW'(BEAT_BYTES - 1);

  tce_state_e    state_q;
  tce_mode_e     mode_q, mode_d;
  logic [AW-1:0] src_q, dst_q, size_q, off;
  logic [DW-1:0] data_q;
  logic          wide_q, src_pitch_q, kind_pitch, last, cmd_fire, adv;
  logic [AW-1:0] lin_addr [2];
  logic [AW-1:0] swz_addr [2];
  logic [AW-1:0] rd_addr, wr_addr;

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign cmd_fire    = cmd_valid_i && cmd_ready_o;
  assign adv         = (state_q == ST_WR) && mem_ack_i;

  tce_kind_decode #(.KW(KW)) u_kind (.kind_i(kind_i), .pitch_o(kind_pitch));
  tce_mode_sel u_mode (.src_pitch_i(src_pitch_q), .dst_pitch_i(kind_pitch), .mode_o(mode_d));

  tce_xfer_ctr #(.AW(AW), .BEAT_BYTES(BEAT_BYTES)) u_ctr (
    .clk_i, .rst_ni, .clr_i(cmd_fire), .adv_i(adv), .wide_i(wide_q),
    .size_i(size_q), .off_o(off), .last_o(last)
  );

  assign lin_addr[0] = src_q + off;
  assign lin_addr[1] = dst_q + off;
  for (genvar s = 0; s < 2; s++) begin : g_side
    tce_addr_swz #(.AW(AW)) u_swz (.addr_i(lin_addr[s]), .addr_o(swz_addr[s]));
  end

  assign rd_addr = (mode_q == MODE_RD_SWZ) ? swz_addr[0] : lin_addr[0];
  assign wr_addr = (mode_q == MODE_WR_SWZ) ? swz_addr[1] : lin_addr[1];

  assign kind_req_o  = (state_q == ST_KSRC) || (state_q == ST_KDST);
  assign kind_addr_o = (state_q == ST_KDST) ? dst_q : src_q;
  assign mem_req_o   = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_wide_o  = wide_q;
  assign mem_addr_o  = mem_we_o ? wr_addr : rd_addr;
  assign mem_wdata_o = data_q;
  assign done_o      = (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      mode_q      <= MODE_LIN;
      src_q       <= '0;
      dst_q       <= '0;
      size_q      <= '0;
      wide_q      <= 1'b0;
      src_pitch_q <= 1'b0;
      data_q      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cmd_valid_i) begin
          src_q   <= cmd_src_i;
          dst_q   <= cmd_dst_i;
          size_q  <= cmd_size_i;
          wide_q  <= ((cmd_src_i | cmd_dst_i | cmd_size_i) & ALIGN_MASK) == '0;
          state_q <= (cmd_size_i == '0) ? ST_DONE : ST_KSRC;
        end
        ST_KSRC: begin
          src_pitch_q <= kind_pitch;
          state_q     <= ST_KDST;
        end
        ST_KDST: begin
          mode_q  <= mode_d;
          state_q <= ST_RD;
        end
        ST_RD: if (mem_ack_i) begin
          data_q  <= mem_rdata_i;
          state_q <= ST_WR;
        end
        ST_WR: if (mem_ack_i) state_q <= last ? ST_DONE : ST_RD;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R12
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  // R9
  rd_after_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_ack_i) |=> !mem_we_o);
  // R8
  zero_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o && cmd_size_i == '0) |=> (done_o && !mem_req_o));
  // R10
  busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || kind_req_o) |-> !cmd_ready_o);
  // R6
  beat_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_wide_o) |-> (mem_addr_o[BW-1:0] == '0));
endmodule

// File: tb/tile_copy_engine_tb.sv
module tile_copy_engine_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [31:0]  cmd_src = '0, cmd_dst = '0, cmd_size = '0;
  logic         kind_req;
  logic [31:0]  kind_addr;
  logic [7:0]   kind;
  logic         mem_req, mem_we, mem_wide, mem_ack = 1'b0;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata, mem_rdata = '0;
  logic         done;

  int total = 0, bad = 0, cyc = 0;
  int rd_cnt = 0, wide_cnt = 0, wr_ack_cyc = 0;
  logic [11:0] last_rd_addr = '0;
  logic [7:0] mem [4096];
  logic [7:0] expm [4096];
  logic [7:0] page_kind [8];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign kind = page_kind[kind_addr[11:9]];

  tile_copy_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_src_i(cmd_src), .cmd_dst_i(cmd_dst), .cmd_size_i(cmd_size),
    .kind_req_o(kind_req), .kind_addr_o(kind_addr), .kind_i(kind),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_wide_o(mem_wide), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack), .done_o(done)
  );

  function automatic logic [11:0] bswz(logic [11:0] a);
    logic [11:0] r = a;
    r[4] = a[6]; r[5] = a[4]; r[6] = a[7]; r[7] = a[8]; r[8] = a[5];
    return r;
  endfunction

  function automatic bit is_lin(logic [7:0] k);
    return (k == 8'h00) || (k == 8'hFD);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model: random 0..2 cycle acknowledge latency
  initial begin
    int wcnt = 0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (mem_req) begin
        if (wcnt == 0) begin
          mem_ack = 1'b1;
          wcnt = $urandom % 3;
          if (!mem_we) begin
            mem_rdata = '0;
            rd_cnt++;
            last_rd_addr = mem_addr[11:0];
            if (mem_wide) begin
              wide_cnt++;
              for (int i = 0; i < 16; i++) mem_rdata[8*i +: 8] = mem[mem_addr[11:0] + 12'(i)];
            end else mem_rdata[7:0] = mem[mem_addr[11:0]];
          end else begin
            wr_ack_cyc = cyc;
            if (mem_wide) for (int i = 0; i < 16; i++) mem[mem_addr[11:0] + 12'(i)] = mem_wdata[8*i +: 8];
            else mem[mem_addr[11:0]] = mem_wdata[7:0];
          end
        end else wcnt--;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic run_cmd(logic [11:0] src, logic [11:0] dst, int size, string req, bit probe);
    bit sp, dp, al;
    int mism = 0, first = -1, waitc = 0;
    sp = is_lin(page_kind[src[11:9]]);
    dp = is_lin(page_kind[dst[11:9]]);
    for (int off = 0; off < size; off++) begin
      logic [11:0] ra, wa;
      ra = src + 12'(off); wa = dst + 12'(off);
      if (!sp && dp) ra = bswz(ra);
      if (sp && !dp) wa = bswz(wa);
      expm[wa] = expm[ra];
    end
    al = ((src | dst | 12'(size)) & 12'hF) == 0;
    rd_cnt = 0; wide_cnt = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_src = 32'(src); cmd_dst = 32'(dst); cmd_size = 32'(size);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (size == 0) begin
      chk(done === 1'b1, "R8", "done after zero size", int'(done), 1);
      chk(rd_cnt == 0, "R8", "accesses for zero size", rd_cnt, 0);
    end else begin
      chk(kind_req && kind_addr == 32'(src), "R11", "first lookup addr", int'(kind_addr), int'(src));
      @(negedge clk);
      chk(kind_req && kind_addr == 32'(dst), "R11", "second lookup addr", int'(kind_addr), int'(dst));
      if (probe) begin
        cmd_valid = 1'b1; cmd_dst = 32'h0000_0E00; cmd_size = 32'd16;
        for (int i = 0; i < 3; i++) begin
          @(negedge clk);
          chk(!cmd_ready, "R10", "ready while busy", int'(cmd_ready), 0);
        end
        cmd_valid = 1'b0;
      end
      while (!done && waitc < 20000) begin @(negedge clk); waitc++; end
      chk(done === 1'b1, "R12", "done reached", int'(done), 1);
      chk(cyc == wr_ack_cyc + 1, "R12", "done cycle", cyc, wr_ack_cyc + 1);
      chk(rd_cnt == (al ? size / 16 : size), "R7", "transfer count", rd_cnt, al ? size / 16 : size);
      chk(wide_cnt == (al ? rd_cnt : 0), "R6", "wide beat count", wide_cnt, al ? rd_cnt : 0);
    end
    @(negedge clk);
    chk(!done, "R12", "done single cycle", int'(done), 0);
    for (int i = 0; i < 4096; i++) if (mem[i] !== expm[i]) begin
      mism++; if (first < 0) first = i;
    end
    chk(mism == 0, req, "memory mismatches (first addr in actual)", first, -1);
  endtask

  initial begin
    logic [7:0] kset [5] = '{8'h00, 8'hFD, 8'h11, 8'hFE, 8'hFF};
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) begin mem[i] = 8'($urandom); expm[i] = mem[i]; end
    for (int i = 0; i < 8; i++) page_kind[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !done && !mem_req, "R10", "reset idle state", {cmd_ready, done, mem_req}, 3'b100);

    // R2 tiled source, pitch destination, full tile
    page_kind[0] = 8'h11; page_kind[4] = 8'h00;
    run_cmd(12'h000, 12'h800, 512, "R2", 1'b0);
    // R3 pitch (0xFD) source, tiled destination; R1
    page_kind[1] = 8'hFD; page_kind[5] = 8'hCB;
    run_cmd(12'h200, 12'hA00, 512, "R3", 1'b0);
    // R4 both tiled
    page_kind[0] = 8'h7B; page_kind[6] = 8'hFF;
    run_cmd(12'h000, 12'hC00, 64, "R4", 1'b0);
    // R4 both pitch, R1 for 0x00/0xFD
    page_kind[1] = 8'hFD; page_kind[6] = 8'h00;
    run_cmd(12'h230, 12'hC40, 48, "R4", 1'b0);
    // R6 byte mode, unaligned, tiled destination
    page_kind[1] = 8'h00; page_kind[4] = 8'hFE;
    run_cmd(12'h203, 12'h805, 37, "R6", 1'b0);
    // R5 single byte from tiled 0x040 reads permuted 0x010
    page_kind[0] = 8'h11; page_kind[4] = 8'h00;
    run_cmd(12'h040, 12'h900, 1, "R5", 1'b0);
    chk(last_rd_addr == 12'h010, "R5", "permuted read addr", int'(last_rd_addr), 'h010);
    // R8 zero size
    run_cmd(12'h100, 12'h900, 0, "R8", 1'b0);
    // R10 command while busy ignored
    page_kind[7] = 8'h00;
    run_cmd(12'h100, 12'h880, 32, "R10", 1'b1);
    repeat (10) @(negedge clk);
    chk(!mem_req && !done, "R10", "no activity after ignored cmd", {mem_req, done}, 0);
    // R9 R7 random mix
    for (int n = 0; n < 40; n++) begin
      logic [11:0] s, d; int sz;
      bit al = $urandom % 2;
      sz = 1 + $urandom % 96;
      s = 12'($urandom % 1024);
      d = 12'h800 + 12'($urandom % 1024);
      if (al) begin s[3:0] = '0; d[3:0] = '0; sz = 16 * (1 + $urandom % 6); end
      page_kind[s[11:9]] = kset[$urandom % 5];
      page_kind[d[11:9]] = kset[$urandom % 5];
      run_cmd(s, d, sz, "R9", 1'b0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule